// File: doc/BRIEF.md
# GF(2^8) Inversion Self-Check Unit

This unit watches the multiplicative-inverse stage of a logic-built AES substitution box, forward or inverse, and flags a result that cannot be correct. It takes the byte entering the inverter and the byte leaving it, multiplies the two in GF(2^8), and compares the product with a reference. The reference is one whenever any of the sixteen observed bits is set. It is zero when all sixteen are clear, because zero maps to zero. Both directions of the cipher use the same inversion, so one unit can be attached to either box.

A parameter sets how many low coefficients of the product take part in the comparison, from one to all eight. Fewer bits give a smaller comparator and weaker coverage. A second parameter places a flip-flop on the error flag so it can meet timing after a deep product tree. The inverter, the affine stage and the round datapath sit outside this block.

Top module: `gf_inv_selfcheck`

## Requirements
- R1: Bytes are field elements in polynomial basis, with bit i holding the coefficient of x^i, reduced by x^8 + x^4 + x^3 + x + 1. Under this encoding (0x53, 0xCA) and (0x02, 0x8D) are inverse pairs.
- R2: For every nonzero input paired with its true inverse, the error flag stays 0.
- R3: An input of 0x00 paired with an output of 0x00 leaves the error flag at 0.
- R4: An input of 0x00 paired with any nonzero output raises the error flag, for every setting of the compared-bit count.
- R5: With all eight product bits compared, flipping any single bit of a correct output for a nonzero input raises the error flag.
- R6: A nonzero input paired with an output of 0x00 raises the error flag.
- R7: With the output register enabled, the flag reflects the pair sampled at the previous rising clock edge and reads 0 while reset is held low. Without the register, the flag follows the inputs combinationally.
- R8: With CMP_BITS = n, only product coefficients 0 to n-1 are compared. A wrong pair whose product matches the reference in those bits is not flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional flag register |
| rst_ni | input | 1 | Active-low synchronous reset of the flag register |
| inv_in_i | input | 8 | Byte presented to the inverter |
| inv_out_i | input | 8 | Byte produced by the inverter |
| err_o | output | 1 | High when the pair fails the product check |

## Verification
The bench drives every one of the 256 correct input/inverse pairs, which covers the all-zero case and the identity 0x01. It then drives every single-bit corruption of each nonzero pair's output. This separates a correct reduction polynomial and full comparison from a design that ignores some product bit. A zero input with nonzero outputs, and nonzero inputs with a zero output, exercise the OR-derived reference in both directions. Pairs such as (0x01, 0x03) are run on a one-bit instance next to the full-width one to show which coefficients the narrow comparison ignores.

// File: rtl/gfchk_pkg.sv
`timescale 1ns/1ps
package gfchk_pkg;

    localparam int GF_W = 8;
    localparam int PROD_W = 2 * GF_W - 1;
    localparam logic [GF_W-1:0] GF_POLY_LOW = 8'h1B;

    typedef struct packed {
        logic err;
    } chk_state_t;

    // residue of x^k in the polynomial basis
    function automatic logic [GF_W-1:0] xpow_row(input int k);
        logic [GF_W-1:0] r;
        r = GF_W'(1);
        for (int i = 0; i < k; i++) begin
            r = r[GF_W-1] ? ((r << 1) ^ GF_POLY_LOW) : (r << 1);
        end
        return r;
    endfunction

    function automatic logic [GF_W-1:0] low_mask(input int n);
        logic [GF_W-1:0] m;
        for (int i = 0; i < GF_W; i++) begin
            m[i] = (i < n);
        end
        return m;
    endfunction

endpackage

// File: rtl/gf_poly_mul.sv
`timescale 1ns/1ps
module gf_poly_mul
    import gfchk_pkg::*;
(
    input  logic [GF_W-1:0]   a_i,
    input  logic [GF_W-1:0]   b_i,
    output logic [PROD_W-1:0] prod_o
);

    // carry-less product, no reduction
    always_comb begin
        prod_o = '0;
        for (int i = 0; i < GF_W; i++) begin
            for (int j = 0; j < GF_W; j++) begin
                prod_o[i+j] = prod_o[i+j] ^ (a_i[i] & b_i[j]);
            end
        end
    end

endmodule

// File: rtl/gf_reduce.sv
`timescale 1ns/1ps
module gf_reduce
    import gfchk_pkg::*;
(
    input  logic [PROD_W-1:0] prod_i,
    output logic [GF_W-1:0]   res_o
);

    localparam int NUM_HI = PROD_W - GF_W;

    logic [GF_W-1:0] fold_term [NUM_HI];

    for (genvar k = 0; k < NUM_HI; k++) begin : g_row
        localparam logic [GF_W-1:0] ROW = xpow_row(GF_W + k);
        assign fold_term[k] = prod_i[GF_W+k] ? ROW : '0;
    end

    always_comb begin
        res_o = prod_i[GF_W-1:0];
        for (int k = 0; k < NUM_HI; k++) begin
            res_o = res_o ^ fold_term[k];
        end
    end

endmodule

// File: rtl/gf_unity_ref.sv
`timescale 1ns/1ps
module gf_unity_ref
    import gfchk_pkg::*;
(
    input  logic [GF_W-1:0] x_i,
    input  logic [GF_W-1:0] y_i,
    output logic [GF_W-1:0] ref_o
);

    always_comb begin
        ref_o    = '0;
        ref_o[0] = (|x_i) | (|y_i);
    end

endmodule

// File: rtl/gf_inv_selfcheck.sv
`timescale 1ns/1ps
module gf_inv_selfcheck
    import gfchk_pkg::*;
#(
    parameter int CMP_BITS = 8,
    parameter bit REG_OUT  = 1'b1
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic [7:0]  inv_in_i,
    input  logic [7:0]  inv_out_i,
    output logic        err_o
);

    localparam logic [GF_W-1:0] CMP_MASK = low_mask(CMP_BITS);

    logic [PROD_W-1:0] raw_prod;
    logic [GF_W-1:0]   field_prod;
    logic [GF_W-1:0]   ref_vec;
    logic              flag_now;

    gf_poly_mul u_mul (
        .a_i    (inv_in_i),
        .b_i    (inv_out_i),
        .prod_o (raw_prod)
    );

    gf_reduce u_red (
        .prod_i (raw_prod),
        .res_o  (field_prod)
    );

    gf_unity_ref u_ref (
        .x_i   (inv_in_i),
        .y_i   (inv_out_i),
        .ref_o (ref_vec)
    );

    always_comb begin
        flag_now = |((field_prod ^ ref_vec) & CMP_MASK);
    end

    if (REG_OUT) begin : g_reg
        chk_state_t state_d, state_q;

        always_comb begin
            state_d     = state_q;
            state_d.err = flag_now;
        end

        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                state_q <= '0;
            end else begin
                state_q <= state_d;
            end
        end

        assign err_o = state_q.err;

        // R7: flag appears one cycle after the offending pair
        a_r7_flag_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
            flag_now |=> err_o);
        a_r7_clear_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !flag_now |=> !err_o);
    end else begin : g_comb
        assign err_o = flag_now;
    end

    // R3: zero maps to zero without complaint
    a_r3_zero_pair_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inv_in_i == 8'h00 && inv_out_i == 8'h00) |-> !flag_now);

    // R4: nonzero output for zero input is always caught
    a_r4_zero_in_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inv_in_i == 8'h00 && inv_out_i != 8'h00) |-> flag_now);

    // R6: lost output for nonzero input is always caught
    a_r6_lost_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inv_in_i != 8'h00 && inv_out_i == 8'h00) |-> flag_now);

    // R2: identity element is its own inverse
    a_r2_identity_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inv_in_i == 8'h01 && inv_out_i == 8'h01) |-> !flag_now);

endmodule

// File: tb/sim_gf_inv_selfcheck.sv
`timescale 1ns/1ps
module sim_gf_inv_selfcheck;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout = 8'h00;
    logic       err_full;
    logic       err_narrow;

    int total = 0;
    int fails = 0;
    logic [7:0] inv_tab [256];

    always #5 clk = ~clk;

    gf_inv_selfcheck #(.CMP_BITS(8), .REG_OUT(1'b1)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .inv_in_i(din), .inv_out_i(dout), .err_o(err_full));

    gf_inv_selfcheck #(.CMP_BITS(1), .REG_OUT(1'b0)) u1 (
        .clk_i(clk), .rst_ni(rst_n), .inv_in_i(din), .inv_out_i(dout), .err_o(err_narrow));

    function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc = 8'h00;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ x;
            x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
        end
        return acc;
    endfunction

    function automatic logic ref_flag(input logic [7:0] a, input logic [7:0] b, input int n);
        logic [7:0] diff;
        diff = ref_mul(a, b) ^ (((a != 0) || (b != 0)) ? 8'h01 : 8'h00);
        for (int i = 0; i < n; i++) begin
            if (diff[i]) return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic chk(input string req, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s din=%02h dout=%02h got=%0b exp=%0b", req, din, dout, got, exp);
        end
    endtask

    // narrow instance is combinational, full instance registers one cycle
    task automatic apply(input logic [7:0] a, input logic [7:0] b, input string req);
        @(negedge clk);
        din  = a;
        dout = b;
        #1 chk({req, " R8 narrow"}, err_narrow, ref_flag(a, b, 1));
        @(negedge clk);
        chk({req, " R7 full"}, err_full, ref_flag(a, b, 8));
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired got=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        for (int a = 0; a < 256; a++) begin
            inv_tab[a] = 8'h00;
            for (int b = 1; b < 256; b++) begin
                if (a != 0 && ref_mul(8'(a), 8'(b)) == 8'h01) inv_tab[a] = 8'(b);
            end
        end

        // R7: reset holds the registered flag low even for a faulty pair
        din  = 8'h00;
        dout = 8'h05;
        repeat (3) @(negedge clk);
        chk("R7 reset", err_full, 1'b0);
        rst_n = 1'b1;

        // R1: known inverse pairs, stated expectations
        apply(8'h53, 8'hCA, "R1");
        chk("R1 0x53/0xCA", err_full, 1'b0);
        apply(8'h02, 8'h8D, "R1");
        chk("R1 0x02/0x8D", err_full, 1'b0);
        apply(8'h53, 8'hCB, "R1");
        chk("R1 0x53/0xCB", err_full, 1'b1);

        // R2 and R3: every correct pair
        for (int a = 0; a < 256; a++) begin
            apply(8'(a), inv_tab[a], (a == 0) ? "R3" : "R2");
            chk((a == 0) ? "R3 quiet" : "R2 quiet", err_full, 1'b0);
        end

        // R5: every single-bit output flip on nonzero inputs
        for (int a = 1; a < 256; a++) begin
            for (int k = 0; k < 8; k++) begin
                apply(8'(a), inv_tab[a] ^ (8'h01 << k), "R5");
                chk("R5 flip", err_full, 1'b1);
            end
        end

        // R4: zero input with nonzero outputs, both widths
        for (int b = 1; b < 256; b += 17) begin
            apply(8'h00, 8'(b), "R4");
            chk("R4 full", err_full, 1'b1);
            chk("R4 narrow", err_narrow, 1'b1);
        end

        // R6: nonzero input with zero output
        for (int a = 1; a < 256; a += 23) begin
            apply(8'(a), 8'h00, "R6");
            chk("R6 full", err_full, 1'b1);
            chk("R6 narrow", err_narrow, 1'b1);
        end

        // R8: fault visible only above coefficient 0
        apply(8'h01, 8'h03, "R8");
        chk("R8 narrow ignores", err_narrow, 1'b0);
        chk("R8 full catches", err_full, 1'b1);
        apply(8'h01, 8'h81, "R8");
        chk("R8 narrow ignores hi", err_narrow, 1'b0);
        apply(8'h01, 8'h02, "R8");
        chk("R8 narrow catches bit0", err_narrow, 1'b1);

        summary();
        $finish;
    end

endmodule